// File: doc/BRIEF.md
# 4:2:2 Byte-Stream Pixel Splitter

This block takes one byte per clock from a multiplexed 4:2:2 video stream, in which two chroma samples and two luma samples share every four clocks, and hands each luma pixel out together with the chroma pair that belongs to it. The clock runs at twice the luma rate, so one pixel leaves the block on every second clock, marked by a single-cycle strobe.

The byte positions are counted from the falling edge of an active-low line sync, so every line starts in a known phase. Two static controls adapt the block to a source that is wired differently. The first exchanges which chroma byte is taken as Cb and which as Cr. The second accepts a stream that arrives one clock late relative to the sync edge. The block produces no output between reset and the first line sync.

Top module: `yc422_demux`

## Requirements
- R1: While reset is asserted, and in the cycle after it, `valid_o` is 0 and `y_o`, `cb_o` and `cr_o` are all zero.
- R2: With both controls low, count bytes from the first byte sampled with `line_sync_n` low after it was sampled high. That byte is slot 0. Slots then repeat modulo 4 with roles Cb (0), first luma (1), Cr (2) and second luma (3).
- R3: With `chroma_swap` high, slot 0 is taken as Cr and slot 2 as Cb. The luma slots are unchanged.
- R4: With `luma_slip` high, every role moves one slot later: first chroma at slot 1, first luma at slot 2, second chroma at slot 3 and second luma at slot 0 of the next count. The byte sampled at the sync edge belongs to no group.
- R5: When the second-luma byte of a complete group is sampled at rising edge k, `valid_o` is high after edge k+1 carrying the first luma and the group's chroma pair. It is high again after edge k+2 carrying the second luma.
- R6: Each complete group gives exactly two valid strobes in consecutive cycles, and both carry the same Cb and Cr. A line of N complete groups gives 2N strobes.
- R7: Every detected sync falling edge restarts the count, even in the middle of a group. Chroma and luma bytes collected before the edge are never output.
- R8: After reset, no strobe occurs until a sync falling edge has been detected.
- R9: While `valid_o` is low, `y_o`, `cb_o` and `cr_o` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock, twice the luma rate |
| rst | input | 1 | Synchronous reset, active high |
| byte_i | input | DATA_W | Multiplexed chroma/luma byte |
| line_sync_n | input | 1 | Line sync, active low; its falling edge sets the phase |
| chroma_swap | input | 1 | Exchange the Cb and Cr slots |
| luma_slip | input | 1 | Accept a stream one clock late |
| y_o | output | DATA_W | Luma sample |
| cb_o | output | DATA_W | Blue-difference sample |
| cr_o | output | DATA_W | Red-difference sample |
| valid_o | output | 1 | One-cycle strobe per luma sample |

## Verification
On every cycle the assertions check the following: a strobe that starts is followed by exactly one more; the chroma pair is shared across those two strobes; the outputs hold while the strobe is low; nothing is output before lock; and the phase count restarts and advances as required. Only the bench scenarios can show that the right bytes land in the right outputs. That covers the default order, the swapped chroma order, the one-clock slip and the discarding of a partial group cut by a mid-line sync. The bench compares these against a queue-based model and against hand-counted strobe totals and first-pixel values.

// File: rtl/yc422_pkg.sv
package yc422_pkg;

   // Role of one byte inside a four-byte 4:2:2 group.
   typedef enum logic [1:0] {
      ROLE_CHROMA_A = 2'd0,
      ROLE_LUMA_A   = 2'd1,
      ROLE_CHROMA_B = 2'd2,
      ROLE_LUMA_B   = 2'd3
   } role_e;

   localparam int unsigned GROUP_BYTES = 4;
   localparam int unsigned SLOT_W      = $clog2(GROUP_BYTES);

   // A slipped stream puts every role one slot later than nominal.
   function automatic role_e slot_to_role(input logic [SLOT_W-1:0] slot,
                                          input logic              slip);
      logic [SLOT_W-1:0] eff;
      eff = slip ? SLOT_W'(slot - 1'b1) : slot;
      return role_e'(eff);
   endfunction

endpackage

// File: rtl/yc422_sync_front.sv
module yc422_sync_front #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned STAGES = 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [DATA_W-1:0] byte_i,
   input  logic              line_sync_n,
   output logic [DATA_W-1:0] byte_q,
   output logic              sync_fall
);

   logic sync_last;
   logic sync_prev;

   generate
      if (STAGES < 1 || STAGES > 4) begin : g_bad_stages
         $error("yc422_sync_front: STAGES must be 1 to 4");
      end

      // Data and sync travel through the same number of registers so they stay aligned.
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         logic [DATA_W-1:0] d_r;
         logic              s_r;
         if (i == 0) begin : g_head
            always_ff @(posedge clk) begin
               if (rst) begin
                  d_r <= '0;
                  s_r <= 1'b1;
               end else begin
                  d_r <= byte_i;
                  s_r <= line_sync_n;
               end
            end
         end else begin : g_tail
            always_ff @(posedge clk) begin
               if (rst) begin
                  d_r <= '0;
                  s_r <= 1'b1;
               end else begin
                  d_r <= g_stage[i-1].d_r;
                  s_r <= g_stage[i-1].s_r;
               end
            end
         end
      end
   endgenerate

   assign byte_q    = g_stage[STAGES-1].d_r;
   assign sync_last = g_stage[STAGES-1].s_r;

   always_ff @(posedge clk) begin
      if (rst) sync_prev <= 1'b1;
      else     sync_prev <= sync_last;
   end

   assign sync_fall = sync_prev & ~sync_last;

   // R7: a falling edge needs a high sample before it, so two in a row cannot occur.
   a_r7_single_fall: assert property (@(posedge clk) disable iff (rst)
      sync_fall |=> !sync_fall);

endmodule

// File: rtl/yc422_phase_track.sv
module yc422_phase_track
   import yc422_pkg::*;
(
   input  logic  clk,
   input  logic  rst,
   input  logic  line_start,
   input  logic  luma_slip,
   output role_e role_o
);

   logic [SLOT_W-1:0] cnt_q;
   logic [SLOT_W-1:0] slot;

   assign slot = line_start ? '0 : cnt_q;

   always_ff @(posedge clk) begin
      if (rst) cnt_q <= '0;
      else     cnt_q <= SLOT_W'(slot + 1'b1);
   end

   assign role_o = slot_to_role(slot, luma_slip);

   // R7: the byte at a sync edge is slot 0, so the counter then holds 1.
   a_r7_restart: assert property (@(posedge clk) disable iff (rst)
      line_start |=> (cnt_q == SLOT_W'(1)));

   // R2: without a sync edge the slot count advances by one per byte.
   a_r2_advance: assert property (@(posedge clk) disable iff (rst)
      !line_start |=> (cnt_q == SLOT_W'($past(cnt_q) + 1'b1)));

endmodule

// File: rtl/yc422_group_build.sv
module yc422_group_build
   import yc422_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [DATA_W-1:0] byte_q,
   input  role_e             role_i,
   input  logic              line_start,
   input  logic              chroma_swap,
   output logic [DATA_W-1:0] y_o,
   output logic [DATA_W-1:0] cb_o,
   output logic [DATA_W-1:0] cr_o,
   output logic              valid_o
);

   localparam logic [2:0] HAVE_ALL = 3'b111;

   logic [DATA_W-1:0] chroma_a_q;
   logic [DATA_W-1:0] chroma_b_q;
   logic [DATA_W-1:0] luma_a_q;
   logic [DATA_W-1:0] luma_b_q;
   logic [2:0]        have_q;
   logic [2:0]        have_base;
   logic [2:0]        have_n;
   logic              locked_q;
   logic              locked_now;
   logic              pend_q;
   logic              emit;
   logic [DATA_W-1:0] cb_sel;
   logic [DATA_W-1:0] cr_sel;

   assign locked_now = locked_q | line_start;
   assign have_base  = line_start ? 3'b000 : have_q;
   assign emit       = locked_now && (role_i == ROLE_LUMA_B) && (have_base == HAVE_ALL);
   assign cb_sel     = chroma_swap ? chroma_b_q : chroma_a_q;
   assign cr_sel     = chroma_swap ? chroma_a_q : chroma_b_q;

   always_comb begin
      have_n = have_base;
      unique case (role_i)
         ROLE_CHROMA_A: have_n = 3'b001;
         ROLE_LUMA_A:   have_n = have_base | 3'b010;
         ROLE_CHROMA_B: have_n = have_base | 3'b100;
         ROLE_LUMA_B:   have_n = 3'b000;
      endcase
      if (!locked_now) have_n = 3'b000;
   end

   // Sample holding registers.
   always_ff @(posedge clk) begin
      if (rst) begin
         chroma_a_q <= '0;
         chroma_b_q <= '0;
         luma_a_q   <= '0;
         have_q     <= '0;
         locked_q   <= 1'b0;
      end else begin
         have_q   <= have_n;
         locked_q <= locked_now;
         unique case (role_i)
            ROLE_CHROMA_A: chroma_a_q <= byte_q;
            ROLE_LUMA_A:   luma_a_q   <= byte_q;
            ROLE_CHROMA_B: chroma_b_q <= byte_q;
            ROLE_LUMA_B:   ;
         endcase
      end
   end

   // Output stage: first luma at the group's last byte, second luma one clock later.
   always_ff @(posedge clk) begin
      if (rst) begin
         y_o      <= '0;
         cb_o     <= '0;
         cr_o     <= '0;
         valid_o  <= 1'b0;
         luma_b_q <= '0;
         pend_q   <= 1'b0;
      end else if (emit) begin
         y_o      <= luma_a_q;
         cb_o     <= cb_sel;
         cr_o     <= cr_sel;
         luma_b_q <= byte_q;
         pend_q   <= 1'b1;
         valid_o  <= 1'b1;
      end else if (pend_q) begin
         y_o      <= luma_b_q;
         pend_q   <= 1'b0;
         valid_o  <= 1'b1;
      end else begin
         valid_o  <= 1'b0;
      end
   end

   // R6: a strobe that starts carries a second one right behind it.
   a_r6_pair: assert property (@(posedge clk) disable iff (rst)
      $rose(valid_o) |=> valid_o);

   // R6: never three strobes in a row.
   a_r6_no_triple: assert property (@(posedge clk) disable iff (rst)
      (valid_o && $past(valid_o)) |=> !valid_o);

   // R6: both luma samples of a group share one chroma pair.
   a_r6_shared_chroma: assert property (@(posedge clk) disable iff (rst)
      (valid_o && $past(valid_o)) |-> ($stable(cb_o) && $stable(cr_o)));

   // R9: outputs hold while no strobe is present.
   a_r9_hold: assert property (@(posedge clk) disable iff (rst)
      !valid_o |-> ($stable(y_o) && $stable(cb_o) && $stable(cr_o)));

   // R8: nothing leaves the block before the first sync edge.
   a_r8_lock: assert property (@(posedge clk) disable iff (rst)
      !locked_q |-> !valid_o);

endmodule

// File: rtl/yc422_demux.sv
module yc422_demux
   import yc422_pkg::*;
#(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned SYNC_STAGES = 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [DATA_W-1:0] byte_i,
   input  logic              line_sync_n,
   input  logic              chroma_swap,
   input  logic              luma_slip,
   output logic [DATA_W-1:0] y_o,
   output logic [DATA_W-1:0] cb_o,
   output logic [DATA_W-1:0] cr_o,
   output logic              valid_o
);

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("yc422_demux: DATA_W must be at least 2");
      end
   endgenerate

   logic [DATA_W-1:0] byte_q;
   logic              sync_fall;
   role_e             role;

   yc422_sync_front #(
      .DATA_W (DATA_W),
      .STAGES (SYNC_STAGES)
   ) u_front (
      .clk         (clk),
      .rst         (rst),
      .byte_i      (byte_i),
      .line_sync_n (line_sync_n),
      .byte_q      (byte_q),
      .sync_fall   (sync_fall)
   );

   yc422_phase_track u_phase (
      .clk        (clk),
      .rst        (rst),
      .line_start (sync_fall),
      .luma_slip  (luma_slip),
      .role_o     (role)
   );

   yc422_group_build #(
      .DATA_W (DATA_W)
   ) u_build (
      .clk         (clk),
      .rst         (rst),
      .byte_q      (byte_q),
      .role_i      (role),
      .line_start  (sync_fall),
      .chroma_swap (chroma_swap),
      .y_o         (y_o),
      .cb_o        (cb_o),
      .cr_o        (cr_o),
      .valid_o     (valid_o)
   );

endmodule

// File: tb/yc422_demux_bench.sv
`timescale 1ns/1ps
module yc422_demux_bench;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [7:0] data_i = '0;
   logic       hs_n = 1'b1;
   logic       cswap = 1'b0;
   logic       slip = 1'b0;
   logic [7:0] y_o, cb_o, cr_o;
   logic       valid_o;

   always #2 clk = ~clk;

   yc422_demux u_yc422_demux (
      .clk         (clk),
      .rst         (rst),
      .byte_i      (data_i),
      .line_sync_n (hs_n),
      .chroma_swap (cswap),
      .luma_slip   (slip),
      .y_o         (y_o),
      .cb_o        (cb_o),
      .cr_o        (cr_o),
      .valid_o     (valid_o)
   );

   int checks = 0;
   int fails  = 0;
   bit done   = 0;
   string cur_req = "R2";

   // Reference model state.
   int m_cnt, m_prev, m_have, m_ca, m_ya, m_cb2;
   bit m_locked;
   int qy[$], qcb[$], qcr[$];
   int p_d, p_h;
   int vcount;
   bit first_seen;
   int first_y, first_cb, first_cr;
   int last_y, last_cb, last_cr;
   bit reset_checked = 0;

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic model_process();
      bit fall;
      int slot, role, cbv, crv;
      fall   = (m_prev == 1) && (p_h == 0);
      m_prev = p_h;
      slot   = fall ? 0 : m_cnt;
      m_cnt  = (slot + 1) % 4;
      role   = slip ? (slot + 3) % 4 : slot;
      if (fall) begin
         m_locked = 1;
         m_have   = 0;
      end
      case (role)
         0: begin m_ca  = p_d; m_have = 1; end
         1: begin m_ya  = p_d; m_have = m_have | 2; end
         2: begin m_cb2 = p_d; m_have = m_have | 4; end
         default: begin
            if (m_locked && m_have == 7) begin
               cbv = cswap ? m_cb2 : m_ca;
               crv = cswap ? m_ca : m_cb2;
               qy.push_back(m_ya); qcb.push_back(cbv); qcr.push_back(crv);
               qy.push_back(p_d);  qcb.push_back(cbv); qcr.push_back(crv);
            end
            m_have = 0;
         end
      endcase
      if (!m_locked) m_have = 0;
   endtask

   task automatic model_step();
      int ey, ecb, ecr;
      if (rst) begin
         m_cnt = 0; m_prev = 1; m_have = 0; m_locked = 0;
         qy.delete(); qcb.delete(); qcr.delete();
         p_d = 0; p_h = 1;
         last_y = 0; last_cb = 0; last_cr = 0;
         if (!reset_checked) begin
            reset_checked = 1;
            check(valid_o == 1'b0, "R1", "reset valid", int'(valid_o), 0);
            check(y_o == 8'd0 && cb_o == 8'd0 && cr_o == 8'd0, "R1", "reset data",
                  int'({y_o, cb_o, cr_o}), 0);
         end
         return;
      end
      model_process();
      if (qy.size() > 0) begin
         ey = qy.pop_front(); ecb = qcb.pop_front(); ecr = qcr.pop_front();
         check(valid_o == 1'b1, "R5", "valid strobe", int'(valid_o), 1);
         check(int'(y_o) == ey,   cur_req, "luma",   int'(y_o),  ey);
         check(int'(cb_o) == ecb, cur_req, "cb",     int'(cb_o), ecb);
         check(int'(cr_o) == ecr, cur_req, "cr",     int'(cr_o), ecr);
      end else begin
         check(valid_o == 1'b0, "R5", "idle strobe", int'(valid_o), 0);
         check(int'(y_o) == last_y && int'(cb_o) == last_cb && int'(cr_o) == last_cr,
               "R9", "hold", int'({y_o, cb_o, cr_o}), (last_y << 16) | (last_cb << 8) | last_cr);
      end
      if (valid_o) begin
         vcount++;
         last_y = int'(y_o); last_cb = int'(cb_o); last_cr = int'(cr_o);
         if (!first_seen) begin
            first_seen = 1;
            first_y = int'(y_o); first_cb = int'(cb_o); first_cr = int'(cr_o);
         end
      end
      p_d = int'(data_i);
      p_h = int'(hs_n);
   endtask

   task automatic tick(input int d, input bit h);
      @(negedge clk);
      model_step();
      data_i = 8'(d);
      hs_n   = h;
   endtask

   task automatic set_rst(input bit r);
      @(negedge clk);
      model_step();
      rst = r;
   endtask

   task automatic restart(input bit sw, input bit sl);
      set_rst(1'b1);
      cswap = sw;
      slip  = sl;
      hs_n  = 1'b1;
      set_rst(1'b1);
      set_rst(1'b0);
      for (int i = 0; i < 3; i++) tick(8'h05 + i, 1'b1);
      vcount = 0;
      first_seen = 0;
   endtask

   initial begin
      set_rst(1'b1);
      set_rst(1'b1);
      set_rst(1'b0);

      // R8: no strobes before the first sync edge.
      cur_req = "R8";
      vcount = 0;
      for (int i = 0; i < 20; i++) tick((i * 13) & 255, 1'b1);
      check(vcount == 0, "R8", "strobes before lock", vcount, 0);

      // R2 / R6: default order, four groups.
      cur_req = "R2";
      vcount = 0; first_seen = 0;
      for (int i = 0; i < 19; i++) tick(8'h10 + i, i < 8 ? 1'b0 : 1'b1);
      check(vcount == 8, "R6", "strobe count", vcount, 8);
      check(first_y == 8'h11, "R2", "first luma", first_y, 8'h11);
      check(first_cb == 8'h10, "R2", "first cb", first_cb, 8'h10);
      check(first_cr == 8'h12, "R2", "first cr", first_cr, 8'h12);

      // R3: chroma order exchanged.
      cur_req = "R3";
      restart(1'b1, 1'b0);
      for (int i = 0; i < 19; i++) tick(8'h40 + i, i < 8 ? 1'b0 : 1'b1);
      check(first_y == 8'h41, "R3", "first luma", first_y, 8'h41);
      check(first_cb == 8'h42, "R3", "first cb", first_cb, 8'h42);
      check(first_cr == 8'h40, "R3", "first cr", first_cr, 8'h40);

      // R4: stream one clock late.
      cur_req = "R4";
      restart(1'b0, 1'b1);
      for (int i = 0; i < 20; i++) tick(8'h80 + i, i < 4 ? 1'b0 : 1'b1);
      check(vcount == 8, "R4", "strobe count", vcount, 8);
      check(first_y == 8'h82, "R4", "first luma", first_y, 8'h82);
      check(first_cb == 8'h81, "R4", "first cb", first_cb, 8'h81);
      check(first_cr == 8'h83, "R4", "first cr", first_cr, 8'h83);

      // R7: mid-group resync drops the partial group.
      cur_req = "R7";
      restart(1'b0, 1'b0);
      for (int i = 0; i < 13; i++)
         tick(8'h20 + i, (i < 2 || i >= 6) ? 1'b0 : 1'b1);
      check(vcount == 4, "R7", "strobe count", vcount, 4);

      // Mixed lines with both controls set, compared cycle by cycle.
      cur_req = "R5";
      restart(1'b1, 1'b1);
      begin
         int lfsr;
         lfsr = 32'h1ACE;
         for (int ln = 0; ln < 8; ln++) begin
            for (int i = 0; i < 40 + ln * 3; i++) begin
               lfsr = (lfsr >> 1) ^ ((lfsr & 1) != 0 ? 32'hB400 : 0);
               tick(lfsr & 255, i < 5 ? 1'b0 : 1'b1);
            end
         end
      end
      for (int i = 0; i < 4; i++) tick(0, 1'b1);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule